// File: doc/BRIEF.md
# Polarity-Corrected GPIO Bank

This block is one bank of up to 32 general-purpose pins controlled through a small memory-mapped register set with separate 32-bit write and read ports. Each pin carries four control bits: a driven value, a direction bit, a hardware blink enable and an input inversion bit. The bank drives the pad output enables and the pad output values. It also samples the pad inputs through a two-flop synchroniser and presents them in a read-only data-in word, with each bit inverted when that pin's inversion bit is set.

Blinking is done in the output path, not by rewriting the stored value. One free-running divider produces a shared phase bit. Every pin whose blink bit is set drives its stored value XORed with that phase, so all blinking pins toggle on the same clock edge. Clearing a blink bit returns the pin to its stored value at once.

Top module: `gpio_polbank`

## Requirements
- R1: After reset the direction word reads all ones (every pin is an input), the value, blink and inversion words read zero, and pad_oe is all zero.
- R2: A write to byte offset 0x00 (value), 0x04 (direction), 0x08 (blink) or 0x0C (inversion) is stored on the clock edge and reads back at that same offset from the next cycle on. Reads are combinational on rd_addr.
- R3: A direction bit of 1 makes the pin an input (pad_oe bit 0). A direction bit of 0 makes it a driven output (pad_oe bit 1). This takes effect in the cycle after the write edge.
- R4: For a pin whose blink bit is 0, pad_out equals that pin's bit of the stored value word.
- R5: Offset 0x10 reads the pad inputs after two synchroniser flops, XORed bit by bit with the inversion word. A pad change is visible after the second clock edge that follows it, and not after the first.
- R6: A write to offset 0x10 changes no stored register and no pad output.
- R7: Any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 (including unaligned byte addresses) reads zero, and a write to it has no effect.
- R8: A pin with its blink bit set drives its stored value XORed with a shared phase bit. The phase toggles once every BLINK_DIV clock cycles, and all blinking pins toggle on the same edge.
- R9: Clearing a blink bit makes the pin drive its stored value from the next cycle on, and leaves the value word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data, bit n controls pin n |
| rd_addr | input | AW | Byte address of the read |
| rd_data | output | 32 | Read data for rd_addr, same cycle |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_oe | output | NPINS | Pad output enables, 1 drives the pad |
| pad_out | output | NPINS | Pad output values |

## Verification
Register writes show up one edge after the write strobe, both in the readback and on pad_oe and pad_out. The bench therefore drives each write on a falling edge and samples on the next falling edge. The data-in word needs two edges after a pad change, so the bench checks it after one edge (old value still expected) and after the second edge (new value). Blink timing is checked by measuring, in falling edges, the gap between two successive toggles of a blinking pin, which must equal BLINK_DIV. Each toggle is also checked to flip both blinking pins together.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int DW = 32;

  localparam logic [31:0] OFS_VAL   = 32'h00;
  localparam logic [31:0] OFS_DIR   = 32'h04;
  localparam logic [31:0] OFS_BLINK = 32'h08;
  localparam logic [31:0] OFS_INV   = 32'h0C;
  localparam logic [31:0] OFS_DIN   = 32'h10;

  typedef enum logic [2:0] {
    SEL_VAL,
    SEL_DIR,
    SEL_BLINK,
    SEL_INV,
    SEL_DIN,
    SEL_NONE
  } gpb_sel_e;

  function automatic gpb_sel_e gpb_decode(input logic [31:0] addr);
    gpb_sel_e s;
    case (addr)
      OFS_VAL:   s = SEL_VAL;
      OFS_DIR:   s = SEL_DIR;
      OFS_BLINK: s = SEL_BLINK;
      OFS_INV:   s = SEL_INV;
      OFS_DIN:   s = SEL_DIN;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpb_regfile.sv
module gpb_regfile
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpb_sel_e         wr_sel,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] val_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] blink_q,
  output logic [NPINS-1:0] inv_q
);
  logic             val_en, dir_en, blink_en, inv_en;
  logic [NPINS-1:0] val_d, dir_d, blink_d, inv_d;

  // Clock enables: only mapped, writable words are touched
  always_comb begin
    val_en   = wr_en && (wr_sel == SEL_VAL);
    dir_en   = wr_en && (wr_sel == SEL_DIR);
    blink_en = wr_en && (wr_sel == SEL_BLINK);
    inv_en   = wr_en && (wr_sel == SEL_INV);
    val_d    = wr_data;
    dir_d    = wr_data;
    blink_d  = wr_data;
    inv_d    = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      inv_q   <= '0;
    end else begin
      if (val_en)   val_q   <= val_d;
      if (dir_en)   dir_q   <= dir_d;
      if (blink_en) blink_q <= blink_d;
      if (inv_en)   inv_q   <= inv_d;
    end
  end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);
  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end
    assign sync_out[i] = stab_q;
  end
endmodule

// File: rtl/gpb_blink.sv
module gpb_blink #(
  parameter int BLINK_DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (BLINK_DIV > 2) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/gpb_readmux.sv
module gpb_readmux
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  gpb_sel_e         rd_sel,
  input  logic [NPINS-1:0] val_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] blink_q,
  input  logic [NPINS-1:0] inv_q,
  input  logic [NPINS-1:0] din,
  output logic [DW-1:0]    rd_data
);
  logic [NPINS-1:0] word;

  always_comb begin
    case (rd_sel)
      SEL_VAL:   word = val_q;
      SEL_DIR:   word = dir_q;
      SEL_BLINK: word = blink_q;
      SEL_INV:   word = inv_q;
      SEL_DIN:   word = din;
      default:   word = '0;
    endcase
    rd_data = DW'(word);
  end
endmodule

// File: rtl/gpio_polbank.sv
module gpio_polbank
  import gpb_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter int AW        = 8,
  parameter int BLINK_DIV = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);
  gpb_sel_e         wr_sel, rd_sel;
  logic [NPINS-1:0] val_q, dir_q, blink_q, inv_q;
  logic [NPINS-1:0] pad_sync, din;
  logic             phase;

  always_comb begin
    wr_sel = gpb_decode(32'(wr_addr));
    rd_sel = gpb_decode(32'(rd_addr));
  end

  gpb_regfile #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data[NPINS-1:0]),
    .val_q   (val_q),
    .dir_q   (dir_q),
    .blink_q (blink_q),
    .inv_q   (inv_q)
  );

  gpb_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpb_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  always_comb begin
    din     = pad_sync ^ inv_q;
    pad_oe  = ~dir_q;
    pad_out = val_q ^ (blink_q & {NPINS{phase}});
  end

  gpb_readmux #(.NPINS(NPINS)) u_rmux (
    .rd_sel  (rd_sel),
    .val_q   (val_q),
    .dir_q   (dir_q),
    .blink_q (blink_q),
    .inv_q   (inv_q),
    .din     (din),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
  import gpb_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [31:0]      wr_data,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] val_q,
  input logic [NPINS-1:0] blink_q
);
  gpb_sel_e sel;
  assign sel = gpb_decode(32'(wr_addr));

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> (pad_oe == ~$past(wr_data[NPINS-1:0])));

  // R6 R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_NONE || sel == SEL_DIN)) |=>
      ($stable(pad_oe) && $stable(val_q) && $stable(blink_q)));

  // R4
  steady_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~blink_q) == (val_q & ~blink_q)));

  // R8
  shared_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_out ^ val_q) & blink_q) == '0) || (((pad_out ^ val_q) & blink_q) == blink_q));

  // R9
  val_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_BLINK) |=> $stable(val_q));
endmodule

bind gpio_polbank gpb_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .val_q   (val_q),
  .blink_q (blink_q)
);

// File: tb/gpio_polbank_test.sv
module gpio_polbank_test;
  localparam int NPINS = 32;
  localparam int AW    = 8;
  localparam int DIV   = 16;

  logic             clk, rst_n, wr_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [31:0]      wr_data, rd_data;
  logic [NPINS-1:0] pad_in, pad_oe, pad_out;

  int applied = 0;
  int bad     = 0;
  bit done    = 0;

  gpio_polbank #(.NPINS(NPINS), .AW(AW), .BLINK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [6] = '{
    {8'h00, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {8'h04, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'h08, 32'h0000_0000, 32'h0000_0000},
    {8'h0C, 32'hF0F0_0000, 32'hF0F0_0000},
    {8'h02, 32'hDEAD_BEEF, 32'h0000_0000},
    {8'h40, 32'h1234_5678, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    applied++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [1:0]  ref01;
    int          gap;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0; pad_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h04, r); chk("R1 dir", r, 32'hFFFF_FFFF);
    rd(8'h00, r); chk("R1 val", r, 32'h0);
    rd(8'h08, r); chk("R1 blink", r, 32'h0);
    rd(8'h0C, r); chk("R1 inv", r, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);

    // R2 R7 vector table
    foreach (VEC[i]) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      chk((VEC[i][31:0] == 32'h0 && VEC[i][63:32] != 32'h0) ? "R7 unmapped" : "R2 readback",
          r, VEC[i][31:0]);
    end

    // R3 direction, R4 steady output
    chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    chk("R4 pad_out", pad_out, 32'hA5A5_5A5A);

    // R5 data-in latency and inversion
    rd(8'h10, r); chk("R5 idle din", r, 32'hF0F0_0000);
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk); rd(8'h10, r); chk("R5 one edge", r, 32'hF0F0_0000);
    @(negedge clk); rd(8'h10, r); chk("R5 two edges", r, 32'hE2C4_5678);

    // R6 write to data-in ignored
    wr(8'h10, 32'h5555_AAAA);
    rd(8'h00, r); chk("R6 val kept", r, 32'hA5A5_5A5A);
    rd(8'h04, r); chk("R6 dir kept", r, 32'h0000_FFFF);
    rd(8'h0C, r); chk("R6 inv kept", r, 32'hF0F0_0000);
    rd(8'h10, r); chk("R6 din kept", r, 32'hE2C4_5678);
    chk("R6 pad_out", pad_out, 32'hA5A5_5A5A);

    // R7 unmapped writes left state alone
    rd(8'h08, r); chk("R7 blink kept", r, 32'h0);
    rd(8'h04, r); chk("R7 dir kept", r, 32'h0000_FFFF);

    // R8 blink: pins 0 and 1, stored bits 1:0 = 2'b10
    wr(8'h08, 32'h0000_0003);
    ref01 = pad_out[1:0];
    gap = 0;
    while (pad_out[1:0] == ref01 && gap < 4*DIV) begin @(negedge clk); gap++; end
    chk("R8 both toggle", 32'(pad_out[1:0] ^ 2'b10) == 0 || pad_out[1:0] == 2'b01 ? 32'h1 : 32'h0, 32'h1);
    ref01 = pad_out[1:0];
    gap = 0;
    while (pad_out[1:0] == ref01 && gap < 4*DIV) begin @(negedge clk); gap++; end
    chk("R8 period", 32'(gap), 32'(DIV));
    chk("R8 joint flip", 32'(pad_out[1:0] ^ ref01), 32'h3);
    chk("R8 others steady", pad_out & 32'hFFFF_FFFC, 32'hA5A5_5A58);

    // R9 clear blink while phase inverts the pins
    while (pad_out[1:0] != 2'b01) @(negedge clk);
    wr(8'h08, 32'h0);
    chk("R9 pad_out", pad_out, 32'hA5A5_5A5A);
    rd(8'h00, r); chk("R9 val kept", r, 32'hA5A5_5A5A);

    finish_run();
  end
endmodule